// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Register File

This block holds the configuration-space registers of one message-signalled interrupt capability. Configuration software reaches them over a dword-wide register port. The port carries a dword index within the capability, per-byte enables, write data and combinational read data. Three elaboration choices shape the block: how many vectors the function can raise (a power of two from 1 to 32), whether message addresses are 64 bits wide, and whether each vector can be masked on its own. Those choices fix the dword layout, the length of the capability and which bits software may change.

Write masks are applied per field and per byte. A requested vector count larger than the function supports is pulled down to the supported count. Reset returns all software state to zero. The decoded enable, vector count, message address, message data, mask and pending values leave the block as plain outputs for the message generator. The message generator in turn marks vectors pending, and clears them, through two vector inputs.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword 0 reads with byte 0 = 0x05 and byte 1 = the NEXT_PTR parameter. The control half holds, read-only: bits [19:17] = log2(NUM_VEC), bit 23 = 1 when ADDR64, bit 24 = 1 when PVMASK. All other control bits read as 0 unless R2 or R3 set them.
- R2: Control bit 16 is the enable bit. Software writes it through byte lane 2, and it drives `msi_en`.
- R3: Control bits [22:20] hold the log2 of the enabled vector count and are written through byte lane 2. A written value above log2(NUM_VEC) is stored as log2(NUM_VEC). The stored value drives `msi_log_en`.
- R4: Dword 1 is the low message address. Bits [1:0] always read as 0, and the other bits are writable. It drives `msi_addr[31:0]`.
- R5: When ADDR64=1, dword 2 is a fully writable high address that drives `msi_addr[63:32]`. When ADDR64=0 there is no high address, `msi_addr[63:32]` is 0, and dword 2 is the data register.
- R6: The 16-bit message data sits in bits [15:0] of dword 3 (ADDR64=1) or dword 2 (ADDR64=0). Bits [31:16] read as 0. It drives `msi_data`.
- R7: When PVMASK=1, the mask register is the dword after the data, and only bits [NUM_VEC-1:0] are writable. When PVMASK=0 there is no mask: that dword reads 0 and `msi_mask` is 0.
- R8: When PVMASK=1, the pending register is the dword after the mask and software cannot write it. A bit set in `pend_set` sets that pending bit and a bit set in `pend_clr` clears it, visible one clock later. Set wins when both hit the same bit. When PVMASK=0, pending is always 0.
- R9: A write changes only the bytes whose byte enable is 1.
- R10: Reset clears the enable, the enabled count, both address words, the data, the mask and the pending bits.
- R11: Dwords outside the configured layout read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 3 | Dword index within the capability |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_word` (combinational) |
| pend_set | input | NUM_VEC | Mark vectors pending |
| pend_clr | input | NUM_VEC | Clear pending vectors |
| msi_en | output | 1 | Capability enable |
| msi_log_en | output | 3 | log2 of the enabled vector count |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | NUM_VEC | Per-vector mask |
| msi_pend | output | NUM_VEC | Per-vector pending |

## Verification
Two sources can change the pending register in the same cycle: the message generator setting a vector and the same generator clearing one. The bench raises `pend_set` and `pend_clr` together on one bit, and clears a different bit in that cycle. It then expects the shared bit set and the other bit cleared on the next clock. A software write to the pending dword in a cycle without set or clear must leave the register unchanged, and the bench checks this by reading the dword back afterwards.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned WORD_W = 3;
  localparam logic [7:0] CAP_ID = 8'h05;

  // Merge write data into a register, byte lane by byte lane, through a write mask.
  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] wd,
                                           input logic [3:0]  be,
                                           input logic [31:0] wmask);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        r[b*8 +: 8] = (old_v[b*8 +: 8] & ~wmask[b*8 +: 8]) |
                      (wd[b*8 +: 8] & wmask[b*8 +: 8]);
      end
    end
    return r;
  endfunction

  // Requested log2 vector count limited to the capable value.
  function automatic logic [2:0] clamp_log(input logic [2:0] req, input logic [2:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // Dword positions that move with the address width.
  function automatic logic [WORD_W-1:0] idx_data(input bit wide);
    return wide ? 3'd3 : 3'd2;
  endfunction

  function automatic logic [WORD_W-1:0] idx_mask(input bit wide);
    return wide ? 3'd4 : 3'd3;
  endfunction

  function automatic logic [WORD_W-1:0] idx_pend(input bit wide);
    return wide ? 3'd5 : 3'd4;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64 = 1'b1,
  parameter bit PVMASK = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output logic              sel_ctrl,
  output logic              sel_alo,
  output logic              sel_ahi,
  output logic              sel_data,
  output logic              sel_mask,
  output logic              sel_pend
);
  localparam logic [WORD_W-1:0] W_DATA = idx_data(ADDR64);
  localparam logic [WORD_W-1:0] W_MASK = idx_mask(ADDR64);
  localparam logic [WORD_W-1:0] W_PEND = idx_pend(ADDR64);

  assign sel_ctrl = (word == 3'd0);
  assign sel_alo  = (word == 3'd1);
  assign sel_ahi  = ADDR64 && (word == 3'd2);
  assign sel_data = (word == W_DATA);
  assign sel_mask = PVMASK && (word == W_MASK);
  assign sel_pend = PVMASK && (word == W_PEND);
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter logic [2:0] CAP_LOG = 3'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lane,
  input  logic [7:0] lane_data,
  output logic       en,
  output logic [2:0] log_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      log_en <= 3'd0;
    end else if (wr_lane) begin
      en     <= lane_data[0];
      log_en <= clamp_log(lane_data[6:4], CAP_LOG);
    end
  end
endmodule

// File: rtl/msi_cap_vector.sv
module msi_cap_vector
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          PVMASK  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask,
  input  logic [3:0]         be,
  input  logic [31:0]        wdata,
  input  logic [NUM_VEC-1:0] pend_set,
  input  logic [NUM_VEC-1:0] pend_clr,
  output logic [NUM_VEC-1:0] mask,
  output logic [NUM_VEC-1:0] pend
);
  localparam logic [31:0] VMASK = 32'hFFFF_FFFF >> (32 - NUM_VEC);

  generate
    if (PVMASK) begin : g_mask
      logic [31:0] mask_wide;
      logic [31:0] mask_next;
      assign mask_wide = 32'(mask);
      assign mask_next = be_merge(mask_wide, wdata, be, VMASK);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= mask_next[NUM_VEC-1:0];
      end

      for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)           pend[v] <= 1'b0;
          else if (pend_set[v]) pend[v] <= 1'b1;
          else if (pend_clr[v]) pend[v] <= 1'b0;
        end
      end
    end else begin : g_nomask
      assign mask = '0;
      assign pend = '0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 8,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVMASK   = 1'b1,
  parameter logic [7:0]  NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_word,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] pend_set,
  input  logic [NUM_VEC-1:0] pend_clr,
  output logic               msi_en,
  output logic [2:0]         msi_log_en,
  output logic [63:0]        msi_addr,
  output logic [15:0]        msi_data,
  output logic [NUM_VEC-1:0] msi_mask,
  output logic [NUM_VEC-1:0] msi_pend
);
  localparam logic [2:0]  CAP_LOG  = 3'($clog2(NUM_VEC));
  localparam logic [31:0] ALO_WM   = 32'hFFFF_FFFC;
  localparam logic [31:0] DATA_WM  = 32'h0000_FFFF;
  localparam logic [15:0] RO_CTRL  = {7'd0, PVMASK, ADDR64, 3'd0, CAP_LOG, 1'b0};

  logic sel_ctrl, sel_alo, sel_ahi, sel_data, sel_mask, sel_pend;
  logic wr_ctrl_lane, wr_alo, wr_ahi, wr_data, wr_mask;
  logic [31:0] addr_lo;
  logic [31:0] addr_hi;
  logic [15:0] data_q;
  logic [15:0] ctrl_word;

  msi_cap_decode #(.ADDR64(ADDR64), .PVMASK(PVMASK)) u_dec (
    .word     (cfg_word),
    .sel_ctrl (sel_ctrl),
    .sel_alo  (sel_alo),
    .sel_ahi  (sel_ahi),
    .sel_data (sel_data),
    .sel_mask (sel_mask),
    .sel_pend (sel_pend)
  );

  assign wr_ctrl_lane = cfg_wr && sel_ctrl && cfg_be[2];
  assign wr_alo       = cfg_wr && sel_alo;
  assign wr_ahi       = cfg_wr && sel_ahi;
  assign wr_data      = cfg_wr && sel_data;
  assign wr_mask      = cfg_wr && sel_mask;

  msi_cap_ctrl #(.CAP_LOG(CAP_LOG)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lane   (wr_ctrl_lane),
    .lane_data (cfg_wdata[23:16]),
    .en        (msi_en),
    .log_en    (msi_log_en)
  );

  msi_cap_vector #(.NUM_VEC(NUM_VEC), .PVMASK(PVMASK)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mask  (wr_mask),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .mask     (msi_mask),
    .pend     (msi_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      data_q  <= '0;
    end else begin
      if (wr_alo)  addr_lo <= be_merge(addr_lo, cfg_wdata, cfg_be, ALO_WM);
      if (wr_data) data_q  <= 16'(be_merge({16'd0, data_q}, cfg_wdata, cfg_be, DATA_WM));
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_hi <= '0;
        else if (wr_ahi) addr_hi <= be_merge(addr_hi, cfg_wdata, cfg_be, 32'hFFFF_FFFF);
      end
    end else begin : g_nohi
      assign addr_hi = '0;
    end
  endgenerate

  assign ctrl_word = RO_CTRL | {9'd0, msi_log_en, 3'd0, msi_en};
  assign msi_addr  = {addr_hi, addr_lo};
  assign msi_data  = data_q;

  always_comb begin
    cfg_rdata = '0;
    if (sel_ctrl)      cfg_rdata = {ctrl_word, NEXT_PTR, CAP_ID};
    else if (sel_alo)  cfg_rdata = addr_lo;
    else if (sel_ahi)  cfg_rdata = addr_hi;
    else if (sel_data) cfg_rdata = {16'd0, data_q};
    else if (sel_mask) cfg_rdata = 32'(msi_mask);
    else if (sel_pend) cfg_rdata = 32'(msi_pend);
  end
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk #(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          PVMASK  = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [3:0]         cfg_be,
  input logic [31:0]        cfg_wdata,
  input logic [NUM_VEC-1:0] pend_set,
  input logic [NUM_VEC-1:0] pend_clr,
  input logic               msi_en,
  input logic [2:0]         msi_log_en,
  input logic [63:0]        msi_addr,
  input logic [15:0]        msi_data,
  input logic [NUM_VEC-1:0] msi_mask,
  input logic [NUM_VEC-1:0] msi_pend,
  input logic               sel_ctrl,
  input logic               sel_alo,
  input logic               sel_ahi,
  input logic               sel_data,
  input logic               sel_mask,
  input logic               sel_pend
);
  localparam logic [2:0] CAP_LOG = 3'($clog2(NUM_VEC));

  AST_LOG_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    msi_log_en <= CAP_LOG); // R3

  AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    msi_addr[1:0] == 2'b00); // R4

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ctrl, sel_alo, sel_ahi, sel_data, sel_mask, sel_pend})); // R11

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(msi_en) && $stable(msi_log_en) && $stable(msi_addr) &&
                 $stable(msi_data) && $stable(msi_mask))); // R9

  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && sel_ctrl && cfg_be[2]) |=> (msi_en == $past(cfg_wdata[16]))); // R2

  generate
    if (PVMASK) begin : g_pend_chk
      AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((msi_pend & $past(pend_set)) == $past(pend_set))); // R8

      AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set == '0 && pend_clr == '0) |=> $stable(msi_pend)); // R8
    end
  endgenerate
endmodule

bind msi_cap_regs msi_cap_chk #(.NUM_VEC(NUM_VEC), .PVMASK(PVMASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_be     (cfg_be),
  .cfg_wdata  (cfg_wdata),
  .pend_set   (pend_set),
  .pend_clr   (pend_clr),
  .msi_en     (msi_en),
  .msi_log_en (msi_log_en),
  .msi_addr   (msi_addr),
  .msi_data   (msi_data),
  .msi_mask   (msi_mask),
  .msi_pend   (msi_pend),
  .sel_ctrl   (sel_ctrl),
  .sel_alo    (sel_alo),
  .sel_ahi    (sel_ahi),
  .sel_data   (sel_data),
  .sel_mask   (sel_mask),
  .sel_pend   (sel_pend)
);

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/1ps
module msi_cap_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_word = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [7:0]  pset_a = '0, pclr_a = '0;
  logic [3:0]  pset_b = '0, pclr_b = '0;
  logic        en_a, en_b;
  logic [2:0]  log_a, log_b;
  logic [63:0] addr_a, addr_b;
  logic [15:0] data_a, data_b;
  logic [7:0]  mask_a, pend_a;
  logic [3:0]  mask_b, pend_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msi_cap_regs #(.NUM_VEC(8), .ADDR64(1'b1), .PVMASK(1'b1), .NEXT_PTR(8'h48)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_a), .pend_set(pset_a), .pend_clr(pclr_a),
    .msi_en(en_a), .msi_log_en(log_a), .msi_addr(addr_a), .msi_data(data_a),
    .msi_mask(mask_a), .msi_pend(pend_a));

  msi_cap_regs #(.NUM_VEC(4), .ADDR64(1'b0), .PVMASK(1'b0), .NEXT_PTR(8'h50)) uut32 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b), .pend_set(pset_b), .pend_clr(pclr_b),
    .msi_en(en_b), .msi_log_en(log_b), .msi_addr(addr_b), .msi_data(data_b),
    .msi_mask(mask_b), .msi_pend(pend_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_word = w; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd_a(input logic [2:0] w, output logic [31:0] v);
    cfg_word = w; #1; v = rdata_a;
  endtask

  task automatic rd_b(input logic [2:0] w, output logic [31:0] v);
    cfg_word = w; #1; v = rdata_b;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd_a(3'd0, v); chk("R1 id/next/ro ctrl", 64'(v), 64'h0186_4805);
    for (int w = 1; w < 8; w++) begin
      rd_a(3'(w), v); chk("R10 word clear after reset", 64'(v), 64'h0);
    end
    chk("R10 exports zero", {en_a, log_a, data_a, mask_a, pend_a}, 64'h0);
    chk("R10 addr zero", addr_a, 64'h0);
  endtask

  task automatic t_control;
    logic [31:0] v;
    wr(3'd0, 4'b0100, 32'h0071_0000);
    rd_a(3'd0, v); chk("R3 clamp to capable log", 64'(v), 64'h01B7_4805);
    chk("R2 enable export", 64'(en_a), 64'h1);
    chk("R3 log export", 64'(log_a), 64'h3);
    wr(3'd0, 4'b1011, 32'hFFFF_FFFF);
    rd_a(3'd0, v); chk("R9 lane 2 off keeps control", 64'(v), 64'h01B7_4805);
    wr(3'd0, 4'b0100, 32'h0020_0000);
    rd_a(3'd0, v); chk("R2 R3 disable and log 2", 64'(v), 64'h01A6_4805);
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
    rd_a(3'd0, v); chk("R1 read-only bits kept", 64'(v), 64'h01B7_4805);
  endtask

  task automatic t_address_data;
    logic [31:0] v;
    wr(3'd1, 4'b1111, 32'hDEAD_BEEF);
    rd_a(3'd1, v); chk("R4 low bits read zero", 64'(v), 64'hDEAD_BEEC);
    wr(3'd1, 4'b0001, 32'h0000_0013);
    rd_a(3'd1, v); chk("R9 R4 single lane", 64'(v), 64'hDEAD_BE10);
    wr(3'd2, 4'b1111, 32'h1234_5678);
    chk("R5 64-bit address export", addr_a, 64'h1234_5678_DEAD_BE10);
    wr(3'd3, 4'b1111, 32'hABCD_1234);
    rd_a(3'd3, v); chk("R6 data upper half zero", 64'(v), 64'h0000_1234);
    chk("R6 data export", 64'(data_a), 64'h1234);
    wr(3'd3, 4'b0010, 32'h0000_5500);
    chk("R9 data high lane only", 64'(data_a), 64'h5534);
  endtask

  task automatic t_mask_pend;
    logic [31:0] v;
    wr(3'd4, 4'b1111, 32'hFFFF_FFFF);
    rd_a(3'd4, v); chk("R7 mask bits above N fixed", 64'(v), 64'h0000_00FF);
    chk("R7 mask export", 64'(mask_a), 64'hFF);
    wr(3'd5, 4'b1111, 32'hFFFF_FFFF);
    rd_a(3'd5, v); chk("R8 pending not software writable", 64'(v), 64'h0);
    @(negedge clk); pset_a = 8'h05;
    @(negedge clk); pset_a = 8'h00;
    rd_a(3'd5, v); chk("R8 pending set", 64'(v), 64'h05);
    pset_a = 8'h01; pclr_a = 8'h05;
    @(negedge clk); pset_a = 8'h00; pclr_a = 8'h00;
    chk("R8 set wins over clear", 64'(pend_a), 64'h01);
    pset_a = 8'h80;
    @(negedge clk); pset_a = 8'h00;
    chk("R8 top vector set", 64'(pend_a), 64'h81);
  endtask

  task automatic t_outside;
    logic [31:0] v;
    wr(3'd6, 4'b1111, 32'hFFFF_FFFF);
    wr(3'd7, 4'b1111, 32'hFFFF_FFFF);
    rd_a(3'd6, v); chk("R11 word 6 reads zero", 64'(v), 64'h0);
    rd_a(3'd7, v); chk("R11 word 7 reads zero", 64'(v), 64'h0);
    rd_a(3'd1, v); chk("R11 addr lo untouched", 64'(v), 64'hDEAD_BE10);
    rd_a(3'd4, v); chk("R11 mask untouched", 64'(v), 64'hFF);
    chk("R11 exports untouched", {en_a, log_a, data_a, pend_a}, {1'b1, 3'd3, 16'h5534, 8'h81});
  endtask

  task automatic t_reset_midway;
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R10 exports cleared", {en_a, log_a, data_a, mask_a, pend_a}, 64'h0);
    chk("R10 address cleared", addr_a, 64'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_layout32;
    logic [31:0] v;
    rd_b(3'd0, v); chk("R1 32-bit control ro", 64'(v), 64'h0004_5005);
    wr(3'd0, 4'b0100, 32'h0071_0000);
    rd_b(3'd0, v); chk("R3 32-bit clamp", 64'(v), 64'h0025_5005);
    wr(3'd2, 4'b1111, 32'hFFFF_FFFF);
    rd_b(3'd2, v); chk("R5 R6 word 2 is data", 64'(v), 64'h0000_FFFF);
    chk("R5 no high address", addr_b, 64'h0);
    wr(3'd3, 4'b1111, 32'hFFFF_FFFF);
    rd_b(3'd3, v); chk("R7 no mask word", 64'(v), 64'h0);
    chk("R7 mask export zero", 64'(mask_b), 64'h0);
    @(negedge clk); pset_b = 4'hF;
    @(negedge clk); pset_b = 4'h0;
    chk("R8 no pending without mask", 64'(pend_b), 64'h0);
    rd_b(3'd4, v); chk("R11 word 4 absent", 64'(v), 64'h0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_control();
    t_address_data();
    t_mask_pend();
    t_outside();
    t_reset_midway();
    t_reset_state();
    do_reset();
    t_layout32();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule